// File: doc/BRIEF.md
# Signed Absolute, Minimum and Maximum Unit

This block is a purely combinational 32-bit arithmetic helper for an integer datapath. From two operands and an operation select it forms one of five results: the absolute value of the first operand, the first operand plus the absolute value of the second, the signed maximum, the signed minimum, or a test for whether any byte of the first operand is zero.

Besides the result it gives a result write enable, a zero-flag value and a zero-flag update enable. Only the zero flag is ever touched. The caller holds all other status flags unchanged, and the block has no outputs for them. Register selection and instruction decode are done outside the block. The surrounding pipeline registers the outputs.

Top module: `sabs_unit`

## Requirements
- R1: With op_sel = 1 (absolute value), result is the two's-complement negation of op_x when op_x is negative as a signed number, and op_x unchanged otherwise. res_we = 1, z_we = 1, and z_val = 1 exactly when result is zero.
- R2: The absolute value of the most negative operand, 0x80000000, wraps to 0x80000000 with z_val = 0.
- R3: With op_sel = 2 (add absolute), result is op_x plus the absolute value of op_y, modulo 2^32. res_we = 1, z_we = 1, and z_val = 1 exactly when result is zero.
- R4: With op_sel = 3 (maximum), result is op_x when op_x is greater than op_y as a signed number, and op_y otherwise. res_we = 1, z_we = 0 and z_val = 0.
- R5: With op_sel = 4 (minimum), result is op_x when op_x is less than op_y as a signed number, and op_y otherwise. res_we = 1, z_we = 0 and z_val = 0.
- R6: When the operands are equal, both maximum and minimum return op_y, which has the same value as op_x.
- R7: With op_sel = 5 (zero-byte test), z_we = 1, res_we = 0 and result = 0. z_val = 1 when any of op_x bits 31:24, 23:16, 15:8 or 7:0 are all zero, and 0 otherwise.
- R8: With op_sel = 0, 6 or 7 (no operation), res_we = 0, z_we = 0, result = 0 and z_val = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | 32 | First operand |
| op_y | input | 32 | Second operand |
| op_sel | input | 3 | Operation select: 0 none, 1 abs, 2 add-abs, 3 max, 4 min, 5 zero-byte test, 6 and 7 none |
| result | output | 32 | Operation result, 0 when no result is written |
| res_we | output | 1 | Result is to be written |
| z_val | output | 1 | New value of the zero flag |
| z_we | output | 1 | Zero flag is to be updated |

## Verification
The absolute-value paths are tried with positive, negative, zero and most-negative operands. This separates a correct negation from a missing increment and from a sign test that treats the top bit wrongly. Maximum and minimum are tried with operands of mixed sign, where a signed and an unsigned comparison give different answers. They are also tried with equal operands, which exposes a wrong tie rule. The zero-byte test clears each byte lane in turn and also uses all-nonzero values, so a missing or shifted lane shows up. The unused codes are checked to make sure they write nothing.

// File: rtl/sabs_pkg.sv
package sabs_pkg;
   typedef enum logic [2:0] {
      SOP_NONE   = 3'd0,
      SOP_ABS    = 3'd1,
      SOP_ADDABS = 3'd2,
      SOP_MAX    = 3'd3,
      SOP_MIN    = 3'd4,
      SOP_ZBYTE  = 3'd5
   } sabs_op_e;
endpackage

// File: rtl/sabs_absval.sv
module sabs_absval #(
   parameter int DATA_W = 32,
   parameter bit ABS_XOR_INC = 1'b1
) (
   input  logic [DATA_W-1:0] val_in,
   input  logic [DATA_W-1:0] addend,
   output logic [DATA_W-1:0] mag_out,
   output logic [DATA_W-1:0] sum_out
);
   localparam int MSB = DATA_W - 1;

   initial begin
      if (DATA_W < 2) $error("sabs_absval: DATA_W must be at least 2");
   end

   logic neg;
   assign neg = val_in[MSB];

   generate
      if (ABS_XOR_INC) begin : g_xor_inc
         logic [DATA_W-1:0] flipped;
         assign flipped = val_in ^ {DATA_W{neg}};
         assign mag_out = flipped + {{(DATA_W-1){1'b0}}, neg};
      end else begin : g_mux
         assign mag_out = neg ? (~val_in + 1'b1) : val_in;
      end
   endgenerate

   assign sum_out = addend + mag_out;

   // R2: result is nonnegative except for the wrapping most-negative input
   always_comb begin
      if (!$isunknown(val_in))
         a_r2_abs_sign: assert (!mag_out[MSB] || (val_in == {1'b1, {(DATA_W-1){1'b0}}}))
            else $error("abs result negative for non-minimum input");
   end
endmodule

// File: rtl/sabs_cmpsel.sv
module sabs_cmpsel #(
   parameter int DATA_W = 32,
   parameter bit CMP_BY_SUB = 1'b1
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] max_out,
   output logic [DATA_W-1:0] min_out
);
   localparam int MSB = DATA_W - 1;

   logic a_gt, a_lt;

   generate
      if (CMP_BY_SUB) begin : g_sub
         logic [DATA_W:0] diff;
         logic lt, eq;
         assign diff = {a_in[MSB], a_in} - {b_in[MSB], b_in};
         assign lt   = diff[DATA_W];
         assign eq   = (a_in == b_in);
         assign a_lt = lt;
         assign a_gt = !lt && !eq;
      end else begin : g_native
         assign a_lt = $signed(a_in) < $signed(b_in);
         assign a_gt = $signed(a_in) > $signed(b_in);
      end
   endgenerate

   assign max_out = a_gt ? a_in : b_in;
   assign min_out = a_lt ? a_in : b_in;

   // R4, R5: selected values bound both operands in signed order
   always_comb begin
      if (!$isunknown({a_in, b_in})) begin
         a_r4_max_bound: assert ($signed(max_out) >= $signed(a_in) && $signed(max_out) >= $signed(b_in))
            else $error("max below an operand");
         a_r5_min_bound: assert ($signed(min_out) <= $signed(a_in) && $signed(min_out) <= $signed(b_in))
            else $error("min above an operand");
      end
   end
endmodule

// File: rtl/sabs_zbyte.sv
module sabs_zbyte #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] val_in,
   output logic              any_zero
);
   localparam int LANES = DATA_W / LANE_W;

   initial begin
      if (LANE_W < 1 || (DATA_W % LANE_W) != 0)
         $error("sabs_zbyte: DATA_W must be a multiple of LANE_W");
   end

   logic [LANES-1:0] lane_zero;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         assign lane_zero[g] = (val_in[g*LANE_W +: LANE_W] == '0);
      end
   endgenerate

   assign any_zero = |lane_zero;

   // R7: an all-zero input must report a zero lane
   always_comb begin
      if (!$isunknown(val_in) && val_in == '0)
         a_r7_zero_word: assert (any_zero) else $error("zero word not flagged");
   end
endmodule

// File: rtl/sabs_unit.sv
module sabs_unit #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   parameter bit ABS_XOR_INC = 1'b1,
   parameter bit CMP_BY_SUB = 1'b1
) (
   input  logic [DATA_W-1:0] op_x,
   input  logic [DATA_W-1:0] op_y,
   input  logic [2:0]        op_sel,
   output logic [DATA_W-1:0] result,
   output logic              res_we,
   output logic              z_val,
   output logic              z_we
);
   import sabs_pkg::*;

   logic [DATA_W-1:0] abs_x, abs_y_unused, sum_xy, mx, mn;
   logic [DATA_W-1:0] sum_x_unused;
   logic              zb;

   sabs_absval #(.DATA_W(DATA_W), .ABS_XOR_INC(ABS_XOR_INC)) u_abs_x (
      .val_in(op_x), .addend('0), .mag_out(abs_x), .sum_out(sum_x_unused)
   );

   sabs_absval #(.DATA_W(DATA_W), .ABS_XOR_INC(ABS_XOR_INC)) u_abs_y (
      .val_in(op_y), .addend(op_x), .mag_out(abs_y_unused), .sum_out(sum_xy)
   );

   sabs_cmpsel #(.DATA_W(DATA_W), .CMP_BY_SUB(CMP_BY_SUB)) u_cmp (
      .a_in(op_x), .b_in(op_y), .max_out(mx), .min_out(mn)
   );

   sabs_zbyte #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_zb (
      .val_in(op_x), .any_zero(zb)
   );

   always_comb begin
      result = '0;
      res_we = 1'b0;
      z_val  = 1'b0;
      z_we   = 1'b0;
      case (op_sel)
         SOP_ABS: begin
            result = abs_x;
            res_we = 1'b1;
            z_we   = 1'b1;
            z_val  = (abs_x == '0);
         end
         SOP_ADDABS: begin
            result = sum_xy;
            res_we = 1'b1;
            z_we   = 1'b1;
            z_val  = (sum_xy == '0);
         end
         SOP_MAX: begin
            result = mx;
            res_we = 1'b1;
         end
         SOP_MIN: begin
            result = mn;
            res_we = 1'b1;
         end
         SOP_ZBYTE: begin
            z_we  = 1'b1;
            z_val = zb;
         end
         default: ;
      endcase
   end

   // R8 and R4: flag and write enables against the select
   always_comb begin
      if (!$isunknown(op_sel)) begin
         a_r8_idle: assert (!((op_sel == 3'd0 || op_sel > 3'd5) && (res_we || z_we)))
            else $error("unused code wrote something");
         a_r4_no_flag: assert (!((op_sel == 3'd3 || op_sel == 3'd4) && z_we))
            else $error("min/max touched Z");
         a_r7_no_result: assert (!(op_sel == 3'd5 && res_we))
            else $error("zero-byte test wrote a result");
      end
   end
endmodule

// File: tb/sabs_unit_tb_top.sv
module sabs_unit_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [31:0] op_x, op_y, result;
   logic [2:0]  op_sel;
   logic        res_we, z_val, z_we;
   int errors = 0, checks = 0;

   sabs_unit dut_i (.op_x(op_x), .op_y(op_y), .op_sel(op_sel),
      .result(result), .res_we(res_we), .z_val(z_val), .z_we(z_we));

   task automatic chk(string req, logic [34:0] act, logic [34:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mag(logic [31:0] v);
      return v[31] ? (32'd0 - v) : v;
   endfunction

   task automatic run(logic [2:0] s, logic [31:0] x, logic [31:0] y);
      @(posedge clk);
      op_sel = s; op_x = x; op_y = y;
      @(negedge clk);
   endtask

   task automatic t_abs(logic [31:0] x, string req);
      logic [31:0] e;
      e = mag(x);
      run(3'd1, x, 32'h5a5a5a5a);
      chk(req, {result, res_we, z_we, z_val}, {e, 1'b1, 1'b1, e == 0});
   endtask

   task automatic t_addabs(logic [31:0] x, logic [31:0] y);
      logic [31:0] e;
      e = x + mag(y);
      run(3'd2, x, y);
      chk("R3", {result, res_we, z_we, z_val}, {e, 1'b1, 1'b1, e == 0});
   endtask

   task automatic t_minmax(logic [31:0] x, logic [31:0] y, string req);
      logic [31:0] e;
      e = ($signed(x) > $signed(y)) ? x : y;
      run(3'd3, x, y);
      chk({req, " max"}, {result, res_we, z_we, z_val}, {e, 1'b1, 1'b0, 1'b0});
      e = ($signed(x) < $signed(y)) ? x : y;
      run(3'd4, x, y);
      chk({req, " min"}, {result, res_we, z_we, z_val}, {e, 1'b1, 1'b0, 1'b0});
   endtask

   task automatic t_zbyte(logic [31:0] x, logic e);
      run(3'd5, x, 32'h0);
      chk("R7", {result, res_we, z_we, z_val}, {32'h0, 1'b0, 1'b1, e});
   endtask

   task automatic t_idle(logic [2:0] s);
      run(s, 32'h12345678, 32'h9abcdef0);
      chk("R8", {result, res_we, z_we, z_val}, 35'h0);
   endtask

   initial begin
      #1600000;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      op_sel = 3'd0; op_x = 32'h0; op_y = 32'h0;
      @(negedge clk);
      chk("R8 reset", {result, res_we, z_we, z_val}, 35'h0);
      t_abs(32'h0000_1234, "R1");
      t_abs(32'hFFFF_FFF6, "R1");
      t_abs(32'h0, "R1");
      t_abs(32'h8000_0000, "R2");
      t_abs(32'h8000_0001, "R1");
      t_addabs(32'h10, 32'hFFFF_FFF0);
      t_addabs(32'hFFFF_FFE0, 32'hFFFF_FFE0);
      t_addabs(32'h7, 32'h100);
      t_addabs(32'h1, 32'h8000_0000);
      t_minmax(32'h5, 32'h3, "R4 R5");
      t_minmax(32'hFFFF_FFFF, 32'h1, "R4 R5");
      t_minmax(32'h7FFF_FFFF, 32'h8000_0000, "R4 R5");
      t_minmax(32'h8000_0000, 32'h8000_0001, "R4 R5");
      t_minmax(32'hDEAD_BEEF, 32'hDEAD_BEEF, "R6");
      t_minmax(32'h0, 32'h0, "R6");
      t_zbyte(32'h0012_3456, 1'b1);
      t_zbyte(32'h1200_3456, 1'b1);
      t_zbyte(32'h1234_0056, 1'b1);
      t_zbyte(32'h1234_5600, 1'b1);
      t_zbyte(32'h0101_0101, 1'b0);
      t_zbyte(32'hFFFF_FFFF, 1'b0);
      t_zbyte(32'h8010_2001, 1'b0);
      t_idle(3'd0);
      t_idle(3'd6);
      t_idle(3'd7);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule